// File: doc/BRIEF.md
# Flash Write-Buffer Command Interface

This block sits on the device side of a flash memory. It decodes bus writes as commands and returns either array contents or a status byte on bus reads. Its main job is the buffered-program sequence. A setup command opens it. A count write follows, giving the number of words minus one. The data words come next, each at its own word address. A confirm command to the same block closes it. The block checks that the writes arrive in this order and stops the operation on any violation, recording a sticky sequence error in status.

After a valid confirm, a simplified array-write engine takes over. It counts a fixed number of busy cycles, then drains the 32-entry buffer into the array memory one entry per cycle. Only entries that were written during the data phase are stored. While the engine runs, status reports busy and bus writes have no effect. Afterwards the interface stays in status mode until a read-array command is written. The host uses it as follows: issue the sequence, poll status until the ready bit returns, check the error bits, then switch back to read-array mode.

Top module: `fwb_cmd_if`

## Requirements
- R1: While `rst` is high, `rdata` goes to 0, the interface enters read-array mode and the sequence error clears. Array contents are not cleared by reset.
- R2: A read (`rd_en`) updates `rdata` on the next clock edge. In read-array mode it returns the array word at `addr`. In every other mode it returns the status byte in `rdata[7:0]` with the upper bits 0. A write of 0x00FF (low byte 0xFF) in read-array or status mode selects read-array mode.
- R3: A write with low byte 0xE8 in read-array or status mode records `addr` as the start address and enters count mode. From then on, reads return status.
- R4: The next write loads `wdata[7:0]` as N, meaning N+1 data words. An N above 31 aborts the operation.
- R5: Each of the next N+1 writes stores `wdata` in buffer entry (`addr` − start) mod 2^ADDR_W. An offset of 32 or more aborts the operation. Writing the same offset twice keeps the last value.
- R6: The write after the last data word is the confirm. It starts programming only if its low byte is 0xD0 and `addr[ADDR_W-1:BLK_LSB]` equals the same bits of the start address. Any other value, or any other block, aborts the operation.
- R7: Starting the cycle after the confirm, status bit 7 reads 0 for PROG_CYCLES+32 cycles and writes are ignored. Afterwards each buffered word is in the array at start+offset, and array words that were not buffered are unchanged. The interface is then in status mode.
- R8: An abort sets the sequence error and puts the interface in status mode. The error stays set until a write with low byte 0x50 is made in read-array or status mode.
- R9: The status byte has bit 7 = ready (not programming), and bits 5 and 4 both equal the sequence error. All other bits are 0. So the idle value is 0x80, the value after an abort is 0xB0, and the value while busy is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data; commands use the low byte |
| rdata | output | DATA_W | Read data, one cycle after `rd_en` |

## Verification
Command decoding takes effect on the edge that captures the write. Read data appears one edge after `rd_en`. The bench therefore drives each strobe on a falling edge and samples `rdata` on the next falling edge. The busy window opens on the cycle after the confirm, so the first status read after a confirm must show 0x00. The bench then polls status with a read limit of PROG_CYCLES+36 before it reads the array. Aborts are checked by reading status on the access that follows the offending write.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

  typedef enum logic [2:0] {
    ST_ARRAY,
    ST_STATUS,
    ST_COUNT,
    ST_DATA,
    ST_CONFIRM,
    ST_WAIT,
    ST_COPY
  } fwb_state_e;

  localparam logic [7:0] CMD_SETUP   = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLRSTAT = 8'h50;
  localparam logic [7:0] CMD_RDARRAY = 8'hFF;

  localparam int STAT_READY = 7;
  localparam int STAT_ERR_A = 5;
  localparam int STAT_ERR_B = 4;

endpackage

// File: rtl/fwb_seq.sv
module fwb_seq
  import fwb_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int BUF_WORDS   = 32,
  parameter int BLK_LSB     = 8,
  parameter int PROG_CYCLES = 20,
  localparam int IDX_W      = $clog2(BUF_WORDS),
  localparam int WAIT_W     = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cmd,
  output logic              buf_we,
  output logic              buf_clr,
  output logic [IDX_W-1:0]  buf_idx,
  output logic [IDX_W-1:0]  copy_idx,
  output logic [ADDR_W-1:0] base,
  output fwb_state_e        state,
  output logic [7:0]        status,
  output logic              idle
);

  fwb_state_e        state_q;
  logic              err_q;
  logic [IDX_W-1:0]  remain_q;
  logic [ADDR_W-1:0] base_q;
  logic [WAIT_W-1:0] wait_q;
  logic [IDX_W-1:0]  copy_q;

  logic [ADDR_W-1:0] offset;
  logic              in_win;
  logic              same_blk;
  logic              ready;

  assign offset   = addr - base_q;
  assign in_win   = offset < ADDR_W'(BUF_WORDS);
  assign same_blk = addr[ADDR_W-1:BLK_LSB] == base_q[ADDR_W-1:BLK_LSB];
  assign idle     = (state_q == ST_ARRAY) || (state_q == ST_STATUS);
  assign ready    = (state_q != ST_WAIT) && (state_q != ST_COPY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_ARRAY;
      err_q    <= 1'b0;
      remain_q <= '0;
      base_q   <= '0;
      wait_q   <= '0;
      copy_q   <= '0;
    end else begin
      case (state_q)
        ST_ARRAY, ST_STATUS: begin
          if (wr_en) begin
            if (cmd == CMD_SETUP) begin
              state_q <= ST_COUNT;
              base_q  <= addr;
            end else if (cmd == CMD_RDARRAY) begin
              state_q <= ST_ARRAY;
            end else if (cmd == CMD_CLRSTAT) begin
              err_q <= 1'b0;
            end
          end
        end
        ST_COUNT: begin
          if (wr_en) begin
            if (cmd > 8'(BUF_WORDS - 1)) begin
              err_q   <= 1'b1;
              state_q <= ST_STATUS;
            end else begin
              remain_q <= cmd[IDX_W-1:0];
              state_q  <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (wr_en) begin
            if (!in_win) begin
              err_q   <= 1'b1;
              state_q <= ST_STATUS;
            end else if (remain_q == '0) begin
              state_q <= ST_CONFIRM;
            end else begin
              remain_q <= remain_q - 1'b1;
            end
          end
        end
        ST_CONFIRM: begin
          if (wr_en) begin
            if (cmd == CMD_CONFIRM && same_blk) begin
              wait_q  <= WAIT_W'(PROG_CYCLES - 1);
              state_q <= ST_WAIT;
            end else begin
              err_q   <= 1'b1;
              state_q <= ST_STATUS;
            end
          end
        end
        ST_WAIT: begin
          if (wait_q == '0) begin
            copy_q  <= '0;
            state_q <= ST_COPY;
          end else begin
            wait_q <= wait_q - 1'b1;
          end
        end
        ST_COPY: begin
          copy_q <= copy_q + 1'b1;
          if (copy_q == IDX_W'(BUF_WORDS - 1)) state_q <= ST_STATUS;
        end
        default: state_q <= ST_ARRAY;
      endcase
    end
  end

  assign buf_we   = (state_q == ST_DATA) && wr_en && in_win;
  assign buf_clr  = idle && wr_en && (cmd == CMD_SETUP);
  assign buf_idx  = offset[IDX_W-1:0];
  assign copy_idx = copy_q;
  assign base     = base_q;
  assign state    = state_q;

  always_comb begin
    status             = 8'h00;
    status[STAT_READY] = ready;
    status[STAT_ERR_A] = err_q;
    status[STAT_ERR_B] = err_q;
  end

endmodule

// File: rtl/fwb_buf.sv
module fwb_buf #(
  parameter int DATA_W = 16,
  parameter int WORDS  = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic [DATA_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  valid_q;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) valid_q <= '0;
    else if (we)    valid_q[widx] <= 1'b1;
  end

  assign rdata  = mem[ridx];
  assign rvalid = valid_q[ridx];

endmodule

// File: rtl/fwb_array.sv
module fwb_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/fwb_cmd_if.sv
module fwb_cmd_if
  import fwb_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int BUF_WORDS   = 32,
  parameter int BLK_LSB     = 8,
  parameter int PROG_CYCLES = 20,
  localparam int IDX_W      = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic              buf_we, buf_clr, buf_rvalid;
  logic [IDX_W-1:0]  buf_idx, copy_idx;
  logic [DATA_W-1:0] buf_rdata;
  logic [ADDR_W-1:0] seq_base;
  fwb_state_e        seq_state;
  logic [7:0]        seq_status;
  logic              seq_idle;

  logic              arr_we, arr_re;
  logic [ADDR_W-1:0] arr_waddr;
  logic [DATA_W-1:0] arr_q;

  logic              sel_arr_q;
  logic [7:0]        stat_q;

  fwb_seq #(
    .ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS),
    .BLK_LSB(BLK_LSB), .PROG_CYCLES(PROG_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .cmd(wdata[7:0]),
    .buf_we(buf_we), .buf_clr(buf_clr), .buf_idx(buf_idx),
    .copy_idx(copy_idx), .base(seq_base), .state(seq_state),
    .status(seq_status), .idle(seq_idle)
  );

  fwb_buf #(.DATA_W(DATA_W), .WORDS(BUF_WORDS)) u_buf (
    .clk(clk), .rst(rst), .clr(buf_clr), .we(buf_we), .widx(buf_idx),
    .wdata(wdata), .ridx(copy_idx), .rdata(buf_rdata), .rvalid(buf_rvalid)
  );

  assign arr_we    = (seq_state == ST_COPY) && buf_rvalid;
  assign arr_waddr = seq_base + ADDR_W'(copy_idx);
  assign arr_re    = rd_en && (seq_state == ST_ARRAY);

  fwb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(buf_rdata),
    .re(arr_re), .raddr(addr), .rdata(arr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_arr_q <= 1'b0;
      stat_q    <= 8'h00;
    end else if (rd_en) begin
      sel_arr_q <= arr_re;
      stat_q    <= seq_status;
    end
  end

  assign rdata = sel_arr_q ? arr_q : {{(DATA_W-8){1'b0}}, stat_q};

endmodule

// File: rtl/fwb_cmd_if_chk.sv
module fwb_cmd_if_chk
  import fwb_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 16,
  parameter int BLK_LSB = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input fwb_state_e        state,
  input logic [7:0]        status,
  input logic              idle,
  input logic [ADDR_W-1:0] base,
  input logic              arr_we
);

  // R1: reset forces read data to zero
  p_rdata_clear_r1: assert property (@(posedge clk)
    rst |=> rdata == '0);

  // R3: setup command from an idle mode opens count mode
  p_setup_count_r3: assert property (@(posedge clk) disable iff (rst)
    (idle && wr_en && wdata[7:0] == CMD_SETUP) |=> state == ST_COUNT);

  // R6: valid confirm makes the engine busy
  p_confirm_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONFIRM && wr_en && wdata[7:0] == CMD_CONFIRM &&
     addr[ADDR_W-1:BLK_LSB] == base[ADDR_W-1:BLK_LSB]) |=> !status[STAT_READY]);

  // R6: wrong confirm value aborts with error
  p_bad_confirm_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONFIRM && wr_en && wdata[7:0] != CMD_CONFIRM)
    |=> (status[STAT_ERR_A] && status[STAT_ERR_B] && state == ST_STATUS));

  // R8: error stays until a clear command in an idle mode
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (status[STAT_ERR_B] && !(idle && wr_en && wdata[7:0] == CMD_CLRSTAT))
    |=> status[STAT_ERR_B]);

  // R7: array is only written while status reads busy
  p_write_busy_r7: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> !status[STAT_READY]);

endmodule

bind fwb_cmd_if fwb_cmd_if_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_LSB(BLK_LSB)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .state(seq_state), .status(seq_status), .idle(seq_idle),
  .base(seq_base), .arr_we(arr_we)
);

// File: tb/fwb_cmd_if_bench.sv
module fwb_cmd_if_bench;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 16;
  localparam int PROG   = 20;
  localparam int POLL_LIMIT = PROG + 36;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  fwb_cmd_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG)) u_fwb_cmd_if (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // op[31:30]: 0 write, 1 read and compare, 2 poll ready then compare
  // req[29:26], addr[25:16], data[15:0]
  localparam int NV = 31;
  localparam logic [31:0] VEC [NV] = '{
    {2'd0, 4'd3, 10'h010, 16'h00E8},  // R3 setup at start 0x010
    {2'd1, 4'd3, 10'h000, 16'h0080},  // R3 status reads ready
    {2'd0, 4'd4, 10'h010, 16'h0003},  // R4 four words
    {2'd0, 4'd5, 10'h010, 16'h1111},
    {2'd0, 4'd5, 10'h011, 16'h2222},
    {2'd0, 4'd5, 10'h013, 16'h4444},
    {2'd0, 4'd5, 10'h012, 16'h3333},
    {2'd1, 4'd9, 10'h000, 16'h0080},  // R9 awaiting confirm
    {2'd0, 4'd6, 10'h0FF, 16'h00D0},  // R6 confirm same block
    {2'd1, 4'd7, 10'h000, 16'h0000},  // R7 busy
    {2'd0, 4'd7, 10'h010, 16'hDEAD},  // R7 ignored while busy
    {2'd2, 4'd7, 10'h000, 16'h0080},  // R7 ready again
    {2'd1, 4'd2, 10'h010, 16'h0080},  // R2 still status mode
    {2'd0, 4'd2, 10'h000, 16'h00FF},  // R2 read array
    {2'd1, 4'd5, 10'h010, 16'h1111},
    {2'd1, 4'd5, 10'h011, 16'h2222},
    {2'd1, 4'd5, 10'h012, 16'h3333},
    {2'd1, 4'd5, 10'h013, 16'h4444},
    {2'd0, 4'd5, 10'h105, 16'h00E8},  // R5 second block, words out of order
    {2'd0, 4'd4, 10'h105, 16'h0001},
    {2'd0, 4'd5, 10'h106, 16'h6666},
    {2'd0, 4'd5, 10'h105, 16'h7777},
    {2'd0, 4'd6, 10'h1FF, 16'h00D0},
    {2'd2, 4'd7, 10'h000, 16'h0080},
    {2'd0, 4'd2, 10'h000, 16'h00FF},
    {2'd1, 4'd5, 10'h105, 16'h7777},
    {2'd1, 4'd5, 10'h106, 16'h6666},
    {2'd0, 4'd7, 10'h013, 16'h00E8},  // R7 single word rewrite
    {2'd0, 4'd4, 10'h013, 16'h0000},
    {2'd0, 4'd5, 10'h013, 16'h5555},
    {2'd0, 4'd6, 10'h013, 16'h00D0}
  };

  task automatic chk(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                     input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic poll(input string req);
    logic [DATA_W-1:0] d;
    int k;
    k = 0;
    do begin
      do_rd('0, d);
      k++;
    end while (!d[7] && k < POLL_LIMIT);
    chk(d, 16'h0080, req);
  endtask

  task automatic run_vectors;
    logic [DATA_W-1:0] d;
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][31:30])
        2'd0: do_wr(VEC[i][25:16], VEC[i][15:0]);
        2'd1: begin
          do_rd(VEC[i][25:16], d);
          chk(d, VEC[i][15:0], $sformatf("R%0d vec %0d", VEC[i][29:26], i));
        end
        default: poll($sformatf("R%0d vec %0d", VEC[i][29:26], i));
      endcase
    end
  endtask

  initial begin : main
    logic [DATA_W-1:0] d;
    repeat (3) @(negedge clk);
    chk(rdata, 16'h0000, "R1 rdata in reset");
    rst = 1'b0;

    run_vectors();
    // finish the rewrite started by the table
    poll("R7 rewrite done");
    do_wr('0, 16'h00FF);
    do_rd(10'h013, d); chk(d, 16'h5555, "R7 rewritten word");
    do_rd(10'h012, d); chk(d, 16'h3333, "R7 neighbour unchanged");

    // R6 wrong confirm value
    do_wr(10'h020, 16'h00E8); do_wr(10'h020, 16'h0000); do_wr(10'h020, 16'hAAAA);
    do_wr(10'h020, 16'h0040);
    do_rd('0, d); chk(d, 16'h00B0, "R6 wrong confirm aborts");
    // R8 sticky across read-array and new setup
    do_wr('0, 16'h00FF);
    do_rd(10'h010, d); chk(d, 16'h1111, "R2 array after abort");
    do_wr(10'h020, 16'h00E8);
    do_rd('0, d); chk(d, 16'h00B0, "R8 error still set");
    do_wr(10'h020, 16'h0020);   // R4 count 32 is too large
    do_rd('0, d); chk(d, 16'h00B0, "R4 count overflow aborts");
    do_wr('0, 16'h0050);
    do_rd('0, d); chk(d, 16'h0080, "R8 clear status");

    // R6 confirm to another block
    do_wr(10'h030, 16'h00E8); do_wr(10'h030, 16'h0000); do_wr(10'h030, 16'hBBBB);
    do_wr(10'h130, 16'h00D0);
    do_rd('0, d); chk(d, 16'h00B0, "R6 other block aborts");
    do_wr('0, 16'h0050);
    do_wr('0, 16'h00FF);
    do_rd(10'h030, d); chk(d[7:0] === 8'hB0 ? 16'h0001 : 16'h0000, 16'h0000,
                           "R6 aborted data not returned as status");

    // R5 window edge: offset 32 aborts
    do_wr(10'h040, 16'h00E8); do_wr(10'h040, 16'h0001); do_wr(10'h060, 16'hCCCC);
    do_rd('0, d); chk(d, 16'h00B0, "R5 offset 32 aborts");
    do_wr('0, 16'h0050);
    // R5 address below start aborts
    do_wr(10'h040, 16'h00E8); do_wr(10'h040, 16'h0001); do_wr(10'h03F, 16'hCCCC);
    do_rd('0, d); chk(d, 16'h00B0, "R5 below start aborts");

    // R1 reset clears error and mode, keeps array
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(rdata, 16'h0000, "R1 rdata after reset");
    rst = 1'b0;
    do_rd(10'h010, d); chk(d, 16'h1111, "R1 read-array mode after reset");
    do_wr(10'h000, 16'h00E8);
    do_rd('0, d); chk(d, 16'h0080, "R1 error cleared by reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule